// File: doc/BRIEF.md
# Program Bank Mapper with Keyed RAM Write Protection

This block sits on the CPU side of a cartridge and decodes the upper half of the address space. Above $8000 it turns each 8 KB CPU window into a program ROM bank number: the three lower windows each follow a bank register written by the CPU, and the top window always points at the last bank of the ROM. Between $6000 and $7FFF it drives the work-RAM select. The RAM write strobe is gated by a protection byte, which has two parts: an unlock key and one protect flag for each 2 KB quarter of the RAM.

All registers are write-only and decode in 2 KB steps, so the block takes only CPU address bits 15..11 (`cpu_page`). Register writes are taken on a rising `clk` edge while `bus_strobe` is high and `cpu_rw` is low. The ROM and RAM outputs are combinational from the current bus cycle.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset all three bank registers read as bank 0 and the protection byte is 0, so no RAM write is granted.
- R2: A write to any address in $E000-$E7FF (page 5'h1C) loads data bits 5..0 as the bank for CPU $8000-$9FFF (pages 5'h10-5'h13). Data bits 7..6 are ignored.
- R3: A write anywhere in $E800-$EFFF (page 5'h1D) loads data bits 5..0 as the bank for $A000-$BFFF (pages 5'h14-5'h17).
- R4: A write anywhere in $F000-$F7FF (page 5'h1E) loads data bits 5..0 as the bank for $C000-$DFFF (pages 5'h18-5'h1B).
- R5: Reads in $E000-$FFFF (pages 5'h1C-5'h1F) always get bank ROM_BANKS-1 (63 by default), whatever the registers hold.
- R6: `ram_ce` is high exactly when `bus_strobe` is high and the page lies in $6000-$7FFF (pages 5'h0C-5'h0F). This holds for reads and for writes.
- R7: A write to $F800-$FFFF (page 5'h1F) stores the protection byte. With key nibble 4'b0100 in bits 7..4, bit i set to 1 protects RAM window i ($6000 + i*$800, where i is page bits 1..0), and bit i at 0 lets `ram_we` rise for a write there. `ram_we` is never high during a read.
- R8: If bits 7..4 of the protection byte are anything other than 4'b0100, `ram_we` stays low in every RAM window.
- R9: A read cycle (`cpu_rw`=1), or a cycle with `bus_strobe` low, leaves every register unchanged, even at a register address.
- R10: `rom_sel` is high only for a strobed read at $8000-$FFFF. Addresses below $6000 raise neither `rom_sel` nor `ram_ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock on which register writes are taken |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_page | input | 5 | CPU address bits 15..11 |
| cpu_data | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| bus_strobe | input | 1 | High while the bus cycle is valid |
| rom_bank | output | 6 | Program ROM 8 KB bank number (address bits above 12) |
| rom_sel | output | 1 | ROM read enable |
| ram_ce | output | 1 | Work-RAM chip enable |
| ram_we | output | 1 | Work-RAM write enable, after protection gating |

## Verification
The assertions assume that `cpu_page`, `cpu_rw` and `bus_strobe` only change away from the rising edge, and that reset is held for at least one edge. Under those conditions the registers are always in a defined state. The bench changes every input just after a falling edge and compares the outputs a nanosecond later. Each register write is a strobed write that covers exactly one rising edge, so no partial or repeated capture can occur. The RAM probes use RAM pages only, so a rising edge during a probe cannot alter any register.

// File: rtl/prg_bank_mapper.sv
`timescale 1ns/1ps
module prg_bank_mapper #(
  parameter int ROM_BANKS = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [4:0]                   cpu_page,
  input  logic [7:0]                   cpu_data,
  input  logic                         cpu_rw,
  input  logic                         bus_strobe,
  output logic [$clog2(ROM_BANKS)-1:0] rom_bank,
  output logic                         rom_sel,
  output logic                         ram_ce,
  output logic                         ram_we
);
  localparam int BANK_W = $clog2(ROM_BANKS);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(ROM_BANKS - 1);
  localparam logic [4:0] PG_BANK8 = 5'h1C;
  localparam logic [4:0] PG_BANKA = 5'h1D;
  localparam logic [4:0] PG_BANKC = 5'h1E;
  localparam logic [4:0] PG_PROT  = 5'h1F;
  localparam logic [3:0] UNLOCK   = 4'b0100;

  logic [BANK_W-1:0] bank8_q, banka_q, bankc_q;
  logic [7:0]        prot_q;
  logic              wr_cyc;

  assign wr_cyc = bus_strobe && !cpu_rw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank8_q <= '0;
      banka_q <= '0;
      bankc_q <= '0;
      prot_q  <= '0;
    end else if (wr_cyc) begin
      case (cpu_page)
        PG_BANK8: bank8_q <= cpu_data[BANK_W-1:0];
        PG_BANKA: banka_q <= cpu_data[BANK_W-1:0];
        PG_BANKC: bankc_q <= cpu_data[BANK_W-1:0];
        PG_PROT:  prot_q  <= cpu_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cpu_page[3:2])
      2'd0:    rom_bank = bank8_q;
      2'd1:    rom_bank = banka_q;
      2'd2:    rom_bank = bankc_q;
      default: rom_bank = LAST_BANK;
    endcase
  end

  assign rom_sel = bus_strobe && cpu_rw && cpu_page[4];
  assign ram_ce  = bus_strobe && (cpu_page[4:2] == 3'b011);
  assign ram_we  = ram_ce && !cpu_rw && (prot_q[7:4] == UNLOCK)
                   && !prot_q[cpu_page[1:0]];
endmodule

module prg_bank_mapper_chk #(
  parameter int BANK_W = 6,
  parameter logic [BANK_W-1:0] LAST_BANK = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        cpu_page,
  input logic              cpu_rw,
  input logic              bus_strobe,
  input logic [BANK_W-1:0] rom_bank,
  input logic              ram_ce,
  input logic              ram_we,
  input logic [7:0]        prot,
  input logic [3*BANK_W-1:0] banks
);
  AST_TOP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_page[4:2] == 3'b111) |-> (rom_bank == LAST_BANK)); // R5
  AST_CE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_ce |-> (bus_strobe && cpu_page[4:2] == 3'b011)); // R6
  AST_WE_IN_CE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_ce && !cpu_rw)); // R7
  AST_KEY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (prot[7:4] == 4'b0100)); // R8
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(bus_strobe) && !$past(cpu_rw)) |-> $stable(banks)); // R9
  AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(bus_strobe) && !$past(cpu_rw)) |-> $stable(prot)); // R9
endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(.BANK_W(BANK_W), .LAST_BANK(LAST_BANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_page(cpu_page), .cpu_rw(cpu_rw),
  .bus_strobe(bus_strobe), .rom_bank(rom_bank), .ram_ce(ram_ce),
  .ram_we(ram_we), .prot(prot_q), .banks({bankc_q, banka_q, bank8_q}));

// File: tb/prg_bank_mapper_tb.sv
`timescale 1ns/1ps
module prg_bank_mapper_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] cpu_page = '0;
  logic [7:0] cpu_data = '0;
  logic       cpu_rw = 1'b1;
  logic       bus_strobe = 1'b0;
  logic [5:0] rom_bank;
  logic       rom_sel, ram_ce, ram_we;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prg_bank_mapper #(.ROM_BANKS(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_page(cpu_page), .cpu_data(cpu_data),
    .cpu_rw(cpu_rw), .bus_strobe(bus_strobe), .rom_bank(rom_bank),
    .rom_sel(rom_sel), .ram_ce(ram_ce), .ram_we(ram_we));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] pg, input logic [7:0] d);
    @(negedge clk);
    cpu_page = pg; cpu_data = d; cpu_rw = 1'b0; bus_strobe = 1'b1;
    @(negedge clk);
    bus_strobe = 1'b0; cpu_rw = 1'b1;
  endtask

  task automatic probe(input logic [4:0] pg, input logic rw, input logic stb);
    @(negedge clk);
    cpu_page = pg; cpu_rw = rw; bus_strobe = stb;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int s = 0; s < 3; s++) begin
      probe(5'h10 + 5'(4*s), 1'b1, 1'b1);
      chk("R1 bank", rom_bank, 0);
    end
    for (int w = 0; w < 4; w++) begin
      probe(5'h0C + 5'(w), 1'b0, 1'b1);
      chk("R1 we", ram_we, 0);
    end
    // R2 R3 R4 sweep every value across the register page and the window
    for (int s = 0; s < 3; s++) begin
      for (int v = 0; v < 256; v++) begin
        wr(5'h1C + 5'(s), 8'(v));
        probe(5'h10 + 5'(4*s) + 5'(v % 4), 1'b1, 1'b1);
        if (s == 0) chk("R2", rom_bank, v % 64);
        else if (s == 1) chk("R3", rom_bank, v % 64);
        else chk("R4", rom_bank, v % 64);
        chk("R10 rom_sel", rom_sel, 1);
      end
    end
    wr(5'h1C, 8'd5); wr(5'h1D, 8'd17); wr(5'h1E, 8'd42);
    // R5 top window
    for (int p = 28; p < 32; p++) begin
      probe(5'(p), 1'b1, 1'b1);
      chk("R5", rom_bank, 63);
    end
    // R9 read cycle and unstrobed write at register pages
    @(negedge clk);
    cpu_page = 5'h1C; cpu_data = 8'd9; cpu_rw = 1'b1; bus_strobe = 1'b1;
    @(negedge clk);
    cpu_page = 5'h1D; cpu_data = 8'd9; cpu_rw = 1'b0; bus_strobe = 1'b0;
    @(negedge clk);
    cpu_page = 5'h1F; cpu_data = 8'h40; cpu_rw = 1'b0; bus_strobe = 1'b0;
    probe(5'h10, 1'b1, 1'b1); chk("R9 bank8", rom_bank, 5);
    probe(5'h14, 1'b1, 1'b1); chk("R9 bankA", rom_bank, 17);
    probe(5'h18, 1'b1, 1'b1); chk("R9 bankC", rom_bank, 42);
    probe(5'h0C, 1'b0, 1'b1); chk("R9 prot", ram_we, 0);
    // R7 R8 sweep all protection bytes and windows
    for (int v = 0; v < 256; v++) begin
      wr(5'h1F, 8'(v));
      for (int w = 0; w < 4; w++) begin
        probe(5'h0C + 5'(w), 1'b0, 1'b1);
        chk("R6 ce write", ram_ce, 1);
        if ((v >> 4) == 4) chk("R7", ram_we, ((v >> w) & 1) ? 0 : 1);
        else chk("R8", ram_we, 0);
        probe(5'h0C + 5'(w), 1'b1, 1'b1);
        chk("R6 ce read", ram_ce, 1);
        chk("R7 read no we", ram_we, 0);
        probe(5'h0C + 5'(w), 1'b0, 1'b0);
        chk("R6 no strobe", ram_ce, 0);
      end
    end
    // R10 low addresses
    wr(5'h1F, 8'h40);
    for (int p = 0; p < 12; p++) begin
      probe(5'(p), 1'b0, 1'b1);
      chk("R10 ce", ram_ce, 0);
      chk("R10 we", ram_we, 0);
      probe(5'(p), 1'b1, 1'b1);
      chk("R10 rom", rom_sel, 0);
    end
    probe(5'h10, 1'b0, 1'b1);
    chk("R10 rom on write", rom_sel, 0);
    finish_run();
  end
endmodule